// File: doc/BRIEF.md
# Serial Queue Flow Event Generator

This block produces the data-flow interrupt events of a serial port. It watches the occupancy of the receive and transmit queues, the strobes that push into and pop from them, the queue-full flags and the line-side character strobe. From these it raises single-cycle event pulses for five conditions: a queue reaching its fill threshold, a write attempted into a full queue, and received data left unread for too long.

The receive timeout counts bit-time ticks only while the receive queue holds data. The count restarts whenever software takes a character out of the queue or the line delivers a new one. This way, a few leftover characters that never reach the receive threshold are still reported. The interrupt state, enable and test registers sit downstream, and the queues and serial engines sit upstream. All outputs are registered pulses.

Top module: `flow_event_gen`

## Requirements
- R1: After a synchronous active-high reset, all five event outputs are low.
- R2: `ev_rx_wmark` pulses high for exactly one cycle, one clock after `rx_level >= rx_thresh` first becomes true (with `rx_thresh` nonzero).
- R3: A watermark event does not repeat while the level stays at or above the threshold. It fires again only after the level has dropped below the threshold and crossed back.
- R4: A threshold of zero disables that queue's watermark event at every level.
- R5: `ev_tx_wmark` follows the same crossing rule as R2 and R3, using `tx_level` and `tx_thresh`.
- R6: A push while the queue's full flag is high gives a one-cycle overflow pulse (`ev_rx_ovf` or `ev_tx_ovf`) on the next cycle. A push while not full gives none.
- R7: With `tmo_en` high and the receive queue non-empty, `ev_rx_tmo` pulses for one cycle, one clock after the `tmo_limit`-th `bit_tick` counted since the last restart.
- R8: A receive pop (`rx_pop`) restarts the timeout count from zero.
- R9: A line-received character strobe (`rx_char`) restarts the timeout count from zero.
- R10: While the receive queue is empty or `tmo_en` is low, the count is held at zero and no timeout event occurs.
- R11: The timeout fires once per expiry. Further ticks give no new event until a restart (R8, R9 or R10) has occurred.
- R12: A `tmo_limit` of zero never produces a timeout event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LW | Receive queue occupancy |
| tx_level | input | LW | Transmit queue occupancy |
| rx_thresh | input | LW | Receive watermark threshold, 0 disables |
| tx_thresh | input | LW | Transmit watermark threshold, 0 disables |
| rx_push | input | 1 | Write strobe into receive queue |
| rx_full | input | 1 | Receive queue full flag |
| tx_push | input | 1 | Write strobe into transmit queue |
| tx_full | input | 1 | Transmit queue full flag |
| rx_pop | input | 1 | Software read from receive queue |
| rx_char | input | 1 | Character received from the line |
| bit_tick | input | 1 | One pulse per bit time |
| tmo_en | input | 1 | Receive timeout enable |
| tmo_limit | input | TW | Timeout length in bit times, 0 never fires |
| ev_rx_wmark | output | 1 | Receive watermark event pulse |
| ev_tx_wmark | output | 1 | Transmit watermark event pulse |
| ev_rx_ovf | output | 1 | Receive overflow event pulse |
| ev_tx_ovf | output | 1 | Transmit overflow event pulse |
| ev_rx_tmo | output | 1 | Receive timeout event pulse |

## Verification
The bench builds the block with its defaults: 32-entry queues, so LW is 6 and levels run up to the full depth, and a 24-bit timeout counter. With those defaults it can drive the extreme level of 32 against a zero threshold and against nonzero thresholds. Bit ticks are driven by hand, so short limits such as 5 make the exact expiry cycle, the restart paths and the no-repeat rule reachable within a few dozen cycles. The wide counter is left unexercised at its top end.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int QDEPTH_DEF = 32;
  localparam int TMO_W_DEF  = 24;

  typedef struct packed {
    logic rx_wmark;
    logic tx_wmark;
    logic rx_ovf;
    logic tx_ovf;
    logic rx_tmo;
  } flow_ev_t;
endpackage

// File: rtl/sfe_level_cross.sv
module sfe_level_cross #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thresh,
  output logic          ev
);
  logic above;
  logic above_q;

  always_comb above = (thresh != '0) && (level >= thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      ev      <= 1'b0;
    end else begin
      above_q <= above;
      ev      <= above & ~above_q;
    end
  end

  // R3: a crossing gives a single pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
  // R4: zero threshold never fires
  a_r4_zero_thresh: assert property (@(posedge clk) disable iff (rst)
    (thresh == '0) |=> !ev);
endmodule

// File: rtl/sfe_drop_flag.sv
module sfe_drop_flag (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic full,
  output logic ev
);
  always_ff @(posedge clk) begin
    if (rst) ev <= 1'b0;
    else     ev <= push & full;
  end

  // R6: overflow only when the queue was full
  a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
    !full |=> !ev);
  a_r6_ovf_on_full_push: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ev);
endmodule

// File: rtl/sfe_rx_timer.sv
module sfe_rx_timer #(
  parameter int LW = 6,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic          pop,
  input  logic          char_in,
  input  logic          tick,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          ev
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] cnt_nxt;
  logic          spent;
  logic          restart;

  always_comb begin
    restart = !en || (level == '0) || pop || char_in;
    cnt_nxt = cnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      spent <= 1'b0;
      ev    <= 1'b0;
    end else begin
      ev <= 1'b0;
      if (restart) begin
        cnt   <= '0;
        spent <= 1'b0;
      end else if (tick && !spent && (limit != '0)) begin
        cnt <= cnt_nxt;
        if (cnt_nxt == limit) begin
          ev    <= 1'b1;
          spent <= 1'b1;
        end
      end
    end
  end

  // R10: nothing fires with an empty queue or when disabled
  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !ev);
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ev);
  // R11: one pulse per expiry
  a_r11_no_repeat: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
  // R8 and R9: a restart cycle never produces an event
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    (pop || char_in) |=> !ev);
  // R12: zero limit never fires
  a_r12_zero_limit: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |=> !ev);
endmodule

// File: rtl/flow_event_gen.sv
module flow_event_gen
  import sfe_pkg::*;
#(
  parameter int QDEPTH = QDEPTH_DEF,
  parameter int TW     = TMO_W_DEF,
  localparam int LW    = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_thresh,
  input  logic [LW-1:0] tx_thresh,
  input  logic          rx_push,
  input  logic          rx_full,
  input  logic          tx_push,
  input  logic          tx_full,
  input  logic          rx_pop,
  input  logic          rx_char,
  input  logic          bit_tick,
  input  logic          tmo_en,
  input  logic [TW-1:0] tmo_limit,
  output logic          ev_rx_wmark,
  output logic          ev_tx_wmark,
  output logic          ev_rx_ovf,
  output logic          ev_tx_ovf,
  output logic          ev_rx_tmo
);
  localparam int NQ = 2;

  logic [NQ-1:0][LW-1:0] q_level;
  logic [NQ-1:0][LW-1:0] q_thresh;
  logic [NQ-1:0]         q_push;
  logic [NQ-1:0]         q_full;
  logic [NQ-1:0]         q_wm_ev;
  logic [NQ-1:0]         q_ovf_ev;
  flow_ev_t              evs;

  assign q_level  = {tx_level, rx_level};
  assign q_thresh = {tx_thresh, rx_thresh};
  assign q_push   = {tx_push, rx_push};
  assign q_full   = {tx_full, rx_full};

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    sfe_level_cross #(.LW(LW)) u_wm (
      .clk    (clk),
      .rst    (rst),
      .level  (q_level[q]),
      .thresh (q_thresh[q]),
      .ev     (q_wm_ev[q])
    );
    sfe_drop_flag u_ovf (
      .clk  (clk),
      .rst  (rst),
      .push (q_push[q]),
      .full (q_full[q]),
      .ev   (q_ovf_ev[q])
    );
  end

  sfe_rx_timer #(.LW(LW), .TW(TW)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .level   (rx_level),
    .pop     (rx_pop),
    .char_in (rx_char),
    .tick    (bit_tick),
    .en      (tmo_en),
    .limit   (tmo_limit),
    .ev      (evs.rx_tmo)
  );

  assign evs.rx_wmark = q_wm_ev[0];
  assign evs.tx_wmark = q_wm_ev[1];
  assign evs.rx_ovf   = q_ovf_ev[0];
  assign evs.tx_ovf   = q_ovf_ev[1];

  assign ev_rx_wmark = evs.rx_wmark;
  assign ev_tx_wmark = evs.tx_wmark;
  assign ev_rx_ovf   = evs.rx_ovf;
  assign ev_tx_ovf   = evs.tx_ovf;
  assign ev_rx_tmo   = evs.rx_tmo;

  // R1: the cycle after reset all events are low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (evs == '0));
endmodule

// File: tb/flow_event_gen_tb.sv
module flow_event_gen_tb;
  localparam int LW = 6;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rst;
  logic [LW-1:0] rx_level, tx_level, rx_thresh, tx_thresh;
  logic rx_push, rx_full, tx_push, tx_full, rx_pop, rx_char, bit_tick, tmo_en;
  logic [TW-1:0] tmo_limit;
  logic ev_rx_wmark, ev_tx_wmark, ev_rx_ovf, ev_tx_ovf, ev_rx_tmo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flow_event_gen u_dut (
    .clk(clk), .rst(rst),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
    .rx_push(rx_push), .rx_full(rx_full),
    .tx_push(tx_push), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_char(rx_char), .bit_tick(bit_tick),
    .tmo_en(tmo_en), .tmo_limit(tmo_limit),
    .ev_rx_wmark(ev_rx_wmark), .ev_tx_wmark(ev_tx_wmark),
    .ev_rx_ovf(ev_rx_ovf), .ev_tx_ovf(ev_tx_ovf), .ev_rx_tmo(ev_rx_tmo)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one bit tick, then one idle cycle; returns the event seen after the tick
  task automatic tick_once(output logic seen);
    bit_tick = 1'b1; step(); seen = ev_rx_tmo;
    bit_tick = 1'b0; step();
  endtask

  task automatic ticks_expect(input int n, input int fire_at, input string tag);
    logic seen;
    for (int i = 1; i <= n; i++) begin
      tick_once(seen);
      chk(seen, (i == fire_at), tag);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk(ev_rx_wmark, 1'b0, "R1 rx_wmark");
    chk(ev_tx_wmark, 1'b0, "R1 tx_wmark");
    chk(ev_rx_ovf,   1'b0, "R1 rx_ovf");
    chk(ev_tx_ovf,   1'b0, "R1 tx_ovf");
    chk(ev_rx_tmo,   1'b0, "R1 rx_tmo");
  endtask

  task automatic t_rx_wmark();
    rx_thresh = 6'd4;
    for (int l = 0; l < 4; l++) begin
      rx_level = LW'(l); step();
      chk(ev_rx_wmark, 1'b0, "R2 below threshold");
    end
    rx_level = 6'd4; step();
    chk(ev_rx_wmark, 1'b1, "R2 crossing pulse");
    rx_level = 6'd5; step();
    chk(ev_rx_wmark, 1'b0, "R3 no repeat above");
    rx_level = 6'd32; step();
    chk(ev_rx_wmark, 1'b0, "R3 no repeat at full");
    rx_level = 6'd2; step();
    chk(ev_rx_wmark, 1'b0, "R3 drop below");
    rx_level = 6'd4; step();
    chk(ev_rx_wmark, 1'b1, "R3 re-cross fires");
    step();
    chk(ev_rx_wmark, 1'b0, "R2 one cycle only");
    rx_level = 6'd0; step();
  endtask

  task automatic t_zero_thresh();
    rx_thresh = 6'd0; tx_thresh = 6'd0;
    rx_level = 6'd32; tx_level = 6'd32; step(); step();
    chk(ev_rx_wmark, 1'b0, "R4 rx zero threshold");
    chk(ev_tx_wmark, 1'b0, "R4 tx zero threshold");
    rx_level = 6'd0; tx_level = 6'd0; step();
  endtask

  task automatic t_tx_wmark();
    tx_thresh = 6'd16;
    tx_level = 6'd15; step();
    chk(ev_tx_wmark, 1'b0, "R5 tx below");
    tx_level = 6'd20; step();
    chk(ev_tx_wmark, 1'b1, "R5 tx crossing");
    step();
    chk(ev_tx_wmark, 1'b0, "R5 tx no repeat");
    tx_level = 6'd0; step();
  endtask

  task automatic t_ovf();
    rx_push = 1'b1; rx_full = 1'b0; step();
    chk(ev_rx_ovf, 1'b0, "R6 rx push not full");
    rx_full = 1'b1; step();
    chk(ev_rx_ovf, 1'b1, "R6 rx push full");
    rx_push = 1'b0; step();
    chk(ev_rx_ovf, 1'b0, "R6 rx full no push");
    rx_full = 1'b0;
    tx_push = 1'b1; tx_full = 1'b1; step();
    chk(ev_tx_ovf, 1'b1, "R6 tx push full");
    chk(ev_rx_ovf, 1'b0, "R6 rx unaffected");
    tx_push = 1'b0; tx_full = 1'b0; step();
    chk(ev_tx_ovf, 1'b0, "R6 tx one cycle");
  endtask

  task automatic t_timeout();
    tmo_limit = 24'd5; tmo_en = 1'b1; rx_thresh = 6'd20;
    rx_level = 6'd3; step();
    ticks_expect(5, 5, "R7 expiry at limit");
    ticks_expect(6, 0, "R11 no repeat after expiry");
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    ticks_expect(5, 5, "R8 pop re-arms");
    ticks_expect(3, 0, "R8 before pop");
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    ticks_expect(5, 5, "R8 pop restarts count");
    rx_char = 1'b1; step(); rx_char = 1'b0;
    ticks_expect(4, 0, "R9 before char");
    rx_char = 1'b1; step(); rx_char = 1'b0;
    ticks_expect(5, 5, "R9 char restarts count");
  endtask

  task automatic t_quiet();
    rx_level = 6'd0; step();
    ticks_expect(8, 0, "R10 empty queue");
    rx_level = 6'd3; tmo_en = 1'b0; step();
    ticks_expect(8, 0, "R10 disabled");
    tmo_en = 1'b1; step();
    ticks_expect(5, 5, "R10 count held at zero");
    tmo_limit = 24'd0; rx_pop = 1'b1; step(); rx_pop = 1'b0;
    ticks_expect(10, 0, "R12 zero limit");
    rx_level = 6'd0; step();
  endtask

  initial begin
    rst = 1'b1;
    rx_level = '0; tx_level = '0; rx_thresh = '0; tx_thresh = '0;
    rx_push = 0; rx_full = 0; tx_push = 0; tx_full = 0;
    rx_pop = 0; rx_char = 0; bit_tick = 0; tmo_en = 0; tmo_limit = '0;
    step();
    t_reset();
    t_rx_wmark();
    t_zero_thresh();
    t_tx_wmark();
    t_ovf();
    t_timeout();
    t_quiet();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule